// File: doc/BRIEF.md
# Presettable Binary Down Counter with Chainable Terminal Count

This block is a down counter of parameterized width (8 bits by default). It counts down by one on each rising clock edge while its active-low count enable is held low. Its value can be replaced by a preset word in two ways: on the next clock edge through a synchronous load, or at once through an asynchronous load. An asynchronous master reset sets every bit of the count to one.

The active-low terminal-count output goes low only when the count is zero and the count enable is low. It is combinational, so a second stage can take it as its count enable. Two stages on the same clock then form a wider down counter with no added register delay. Left to count freely, the block wraps from zero to all ones, so one full pass takes 2^WIDTH clocks. The current count is also brought out as a parallel value.

Top module: `down_counter_tc`

## Requirements
- R1: While rst_n is low, value becomes all ones (255) at once, with or without a clock edge and whatever the other inputs are; tc_n is then high.
- R2: On a rising clock edge with rst_n, aload_n and sload_n high and cnt_en_n low, value decreases by one.
- R3: On a rising clock edge with rst_n, aload_n, sload_n and cnt_en_n all high, value keeps its previous value.
- R4: On a rising clock edge with sload_n low (and rst_n, aload_n high), value takes preset whether cnt_en_n is high or low.
- R5: A falling aload_n puts preset into value at once, between clock edges. While aload_n stays low, clock edges load preset again, and sload_n and cnt_en_n have no effect.
- R6: When counting from 0 with cnt_en_n low, the next value is 255, so a free-running count returns to its start value after exactly 256 clocks.
- R7: tc_n is low exactly when value is 0 and cnt_en_n is low, and it follows cnt_en_n without waiting for a clock edge.
- R8: In free counting, tc_n stays low for exactly one clock period out of each 256.
- R9: Two instances on one clock, the upper one's cnt_en_n driven by the lower one's tc_n, count as one 16-bit down counter {upper, lower} starting from 0xFFFF.
- R10: Precedence is rst_n over aload_n, aload_n over sload_n, and sload_n over counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous master reset to all ones, active low |
| aload_n | input | 1 | Asynchronous preset load, active low |
| sload_n | input | 1 | Synchronous preset load, active low |
| cnt_en_n | input | 1 | Count enable, active low; also gates tc_n |
| preset | input | WIDTH | Preset word |
| value | output | WIDTH | Current count |
| tc_n | output | 1 | Terminal count, active low, combinational |

## Verification
A wrong count shows on value after the clock edge that caused it. In a chain, it also shows as a borrow into the upper stage at the wrong cycle. A missed wrap or a missed borrow shifts every later tc_n pulse, so a single pass of 256 clocks exposes it. A fault on an asynchronous path shows before the next clock edge: the bench reads value in the middle of a clock phase, just after driving aload_n or rst_n.

// File: rtl/down_counter_tc.sv
module down_counter_tc #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             aload_n,
  input  logic             sload_n,
  input  logic             cnt_en_n,
  input  logic [WIDTH-1:0] preset,
  output logic [WIDTH-1:0] value,
  output logic             tc_n
);
  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  logic [WIDTH-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n or negedge aload_n) begin
    if (!rst_n)         cnt_q <= '1;
    else if (!aload_n)  cnt_q <= preset;
    else if (!sload_n)  cnt_q <= preset;
    else if (!cnt_en_n) cnt_q <= cnt_q - ONE;
  end

  assign value = cnt_q;
  assign tc_n  = ~((cnt_q == '0) & ~cnt_en_n);
endmodule

module down_counter_tc_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             aload_n,
  input logic             sload_n,
  input logic             cnt_en_n,
  input logic [WIDTH-1:0] preset,
  input logic [WIDTH-1:0] value,
  input logic             tc_n
);
  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  // R1
  always @(posedge clk)
    if (!rst_n) rst_max_chk: assert (value == '1 && tc_n);

  // R2
  dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n || !aload_n)
    (sload_n && !cnt_en_n) |=> value == $past(value) - ONE);

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n || !aload_n)
    (sload_n && cnt_en_n) |=> $stable(value));

  // R4
  sync_load_chk: assert property (@(posedge clk) disable iff (!rst_n || !aload_n)
    !sload_n |=> value == $past(preset));

  // R7
  tc_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tc_n |-> !cnt_en_n);

  // R8
  tc_single_chk: assert property (@(posedge clk) disable iff (!rst_n || !aload_n)
    (!tc_n && sload_n) |=> tc_n);
endmodule

bind down_counter_tc down_counter_tc_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .aload_n(aload_n), .sload_n(sload_n),
  .cnt_en_n(cnt_en_n), .preset(preset), .value(value), .tc_n(tc_n)
);

// File: tb/test_down_counter_tc.sv
`timescale 1ns/1ps
module test_down_counter_tc;
  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic       aload_n = 1'b1;
  logic       sload_n = 1'b1;
  logic       cnt_en_n = 1'b1;
  logic [7:0] preset = 8'h00;
  logic       hi_sload_n = 1'b1;
  logic [7:0] value, hi_value;
  logic       tc_n, hi_tc_n;
  int         checks = 0;
  int         failures = 0;

  always #2.5 clk = ~clk;

  down_counter_tc #(.WIDTH(8)) i_down_counter_tc (
    .clk(clk), .rst_n(rst_n), .aload_n(aload_n), .sload_n(sload_n),
    .cnt_en_n(cnt_en_n), .preset(preset), .value(value), .tc_n(tc_n));

  down_counter_tc #(.WIDTH(8)) i_down_counter_tc_hi (
    .clk(clk), .rst_n(rst_n), .aload_n(1'b1), .sload_n(hi_sload_n),
    .cnt_en_n(tc_n), .preset(8'h00), .value(hi_value), .tc_n(hi_tc_n));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // {sload_n, cnt_en_n, preset, expected value, expected tc_n}
  localparam logic [18:0] VEC [0:9] = '{
    {1'b0, 1'b1, 8'h03, 8'h03, 1'b1},  // R4 load while holding
    {1'b1, 1'b0, 8'h00, 8'h02, 1'b1},  // R2
    {1'b1, 1'b1, 8'h00, 8'h02, 1'b1},  // R3
    {1'b1, 1'b0, 8'h00, 8'h01, 1'b1},  // R2
    {1'b1, 1'b0, 8'h00, 8'h00, 1'b0},  // R7 zero and enabled
    {1'b1, 1'b1, 8'h00, 8'h00, 1'b1},  // R7 zero but disabled
    {1'b1, 1'b0, 8'h00, 8'hFF, 1'b1},  // R6 wrap
    {1'b0, 1'b0, 8'h00, 8'h00, 1'b0},  // R4 load while enabled
    {1'b1, 1'b0, 8'h00, 8'hFF, 1'b1},  // R6
    {1'b0, 1'b0, 8'hA5, 8'hA5, 1'b1}   // R10 load over count
  };

  initial begin
    #900000;
    checks++; failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int tc_lows;
    #1 rst_n = 1'b0;
    #0.5;
    chk("R1 reset value", value, 8'hFF);
    chk("R1 reset tc_n", tc_n, 1'b1);
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      {sload_n, cnt_en_n, preset} = VEC[i][18:9];
      @(posedge clk); #1;
      chk($sformatf("vector %0d value", i), value, VEC[i][8:1]);
      chk($sformatf("vector %0d tc_n", i), tc_n, VEC[i][0]);
    end

    // R7: tc_n follows cnt_en_n between edges
    @(negedge clk); sload_n = 1'b0; preset = 8'h00; cnt_en_n = 1'b1;
    @(negedge clk); sload_n = 1'b1; #0.5;
    chk("R7 tc_n high when disabled", tc_n, 1'b1);
    cnt_en_n = 1'b0; #0.5;
    chk("R7 tc_n low without edge", tc_n, 1'b0);
    cnt_en_n = 1'b1;

    // R6 R8: full free-running pass from 255
    @(negedge clk); sload_n = 1'b0; preset = 8'hFF;
    @(negedge clk); sload_n = 1'b1; cnt_en_n = 1'b0;
    tc_lows = 0;
    for (int n = 1; n <= 256; n++) begin
      @(posedge clk); #1;
      if (!tc_n) tc_lows++;
      if (n == 255) chk("R6 zero after 255 clocks", value, 8'h00);
    end
    chk("R6 back to start after 256 clocks", value, 8'hFF);
    chk("R8 one tc_n low per pass", tc_lows, 1);

    // R5: async load between edges, held through an edge
    @(negedge clk); cnt_en_n = 1'b0; sload_n = 1'b0; preset = 8'h3C;
    #1 aload_n = 1'b0; #0.2;
    chk("R5 async load before edge", value, 8'h3C);
    @(posedge clk); #1;
    chk("R5 holds preset through edge", value, 8'h3C);
    @(negedge clk); aload_n = 1'b1; sload_n = 1'b1;
    @(posedge clk); #1;
    chk("R2 counts after async release", value, 8'h3B);

    // R10 R1: reset beats async load; async load resumes on clock
    @(negedge clk); preset = 8'h42; aload_n = 1'b0; rst_n = 1'b0; #0.5;
    chk("R10 reset over async load", value, 8'hFF);
    @(negedge clk); rst_n = 1'b1; #0.5;
    chk("R10 value kept at release", value, 8'hFF);
    @(posedge clk); #1;
    chk("R5 async load overrides clock", value, 8'h42);
    @(negedge clk); aload_n = 1'b1; cnt_en_n = 1'b1;

    // R1: reset between edges
    #1 rst_n = 1'b0; #0.2;
    chk("R1 async reset mid cycle", value, 8'hFF);
    @(negedge clk); rst_n = 1'b1;

    // R9: 16-bit chain from 0xFFFF
    rst_n = 1'b0; #1 rst_n = 1'b1;
    @(negedge clk); cnt_en_n = 1'b0;
    for (int n = 1; n <= 600; n++) begin
      @(posedge clk); #1;
      if (n == 255 || n == 256 || n == 257 || n == 512 || n == 600)
        chk($sformatf("R9 chain after %0d clocks", n), {hi_value, value}, 16'hFFFF - n);
    end
    cnt_en_n = 1'b1;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule